// File: doc/BRIEF.md
# Banked Private-Interrupt Configuration Registers

This block keeps the configuration state of one core's 32 private interrupts. Interrupts 0 to 15 are software-generated. Interrupts 16 to 31 come from peripherals. A simple register bus reads and writes the state in byte, word or doubleword accesses. Each request carries a secure attribute, and a global security-disable input tells the block whether security is enforced at all. The stored state is:

- a group bit per interrupt;
- a group-modifier bitmap;
- enable, pending and active bitmaps, each with separate set and clear addresses;
- an 8-bit priority per interrupt;
- edge/level trigger configuration;
- a 2-bit non-secure access field per software-generated interrupt;
- a sleep-request/asleep control word.

A non-secure request made while security is enforced is restricted. It can see and change only the bits of interrupts whose group bit is 1. It gets a shifted view of the priorities of those interrupts. The enable, pending, active and edge bitmaps go out as ports to the pending-latch and arbitration logic beside the block.

Every request gets a response one cycle later on `rsp_valid`, with `rsp_err` raised for unmapped offsets, unsupported sizes and misaligned words.

Top module: `irq_bank_regs`

## Requirements
- R1: After reset, all bitmaps, the group, group-modifier, access and sleep registers, all priorities and the response outputs are zero.
- R2: Each request cycle gives exactly one response cycle, registered on the next clock edge. The following requests get `rsp_err`=1 and `rsp_rdata`=0:
  - size 1 (halfword);
  - a byte access outside the priority window;
  - a misaligned word;
  - a doubleword anywhere except offset 0x008;
  - any unmapped word offset.
- R3: A request is restricted when `secure`=0 and `sec_dis`=0. A restricted read of a bitmap returns only the bits whose group bit is 1, and a restricted write changes only those bits. Otherwise all 32 bits are accessible.
- R4: Enable (set 0x100, clear 0x180), pending (set 0x200, clear 0x280) and active (set 0x300, clear 0x380) work the same way: a 1 written to the set address sets that bit, a 1 written to the clear address clears it, and both addresses read the same (masked) value.
- R5: The group register at 0x080 reads as zero and ignores writes for a restricted request.
- R6: A restricted priority read returns (stored << 1) truncated to 8 bits for a group-1 interrupt and 0 for a group-0 interrupt.
- R7: A restricted priority write to a group-1 interrupt stores 0x80 | (value >> 1). The same write to a group-0 interrupt is ignored.
- R8: Priorities sit at 0x400 + irq and support byte and word access. A word at 0x400+4n covers interrupts 4n..4n+3, with byte lane k (bits 8k+7:8k) holding interrupt 4n+k.
- R9: Trigger words sit at 0x C00 (interrupts 0-15) and 0xC04 (interrupts 16-31). Interrupt j of a word uses bits 2j+1:2j, of which only bit 2j+1 (1 = edge) is stored. Reads show the edge bits under the R3 mask. Writes to 0xC00 are ignored. Writes to 0xC04 update edge bits 16-31 under the R3 mask.
- R10: The group-modifier register (0xD00) and the access-control register (0xE00, 2 bits per software interrupt at bits 2i+1:2i) read as zero and ignore writes when `sec_dis`=1 or `secure`=0.
- R11: In the wake word at 0x000, only bit 0 (sleep request) is writable, and bit 1 (asleep) always reads equal to bit 0.
- R12: The identification value `ID_VALUE` reads at word 0x008 (low half), word 0x00C (high half) and doubleword 0x008. Writes to these offsets are ignored without an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request valid for one cycle |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | ADDR_W | Byte offset inside the core's page |
| size | input | 2 | 0 byte, 1 halfword (unsupported), 2 word, 3 doubleword |
| wdata | input | 64 | Write data, right-aligned |
| secure | input | 1 | Secure attribute of the request |
| sec_dis | input | 1 | Global security disable |
| rsp_valid | output | 1 | Response valid, one cycle after req |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 64 | Read data, zero for writes and errors |
| en_map | output | N_IRQ | Enable bitmap |
| pend_map | output | N_IRQ | Pending bitmap |
| act_map | output | N_IRQ | Active bitmap |
| edge_map | output | N_IRQ | Edge-trigger bitmap |

## Verification
The assertions check the following on every cycle:
- the response follows each request one cycle later, and error responses carry zero data;
- a misaligned word always errors;
- a restricted write never changes an enable, pending, active or edge bit of a group-0 interrupt;
- a clear write never sets an enable bit;
- a write to the lower trigger word leaves the edge bitmap unchanged.

Only the bench's scenarios can show the rest:
- the shifted non-secure priority encoding;
- the byte-lane order of word priority accesses;
- the spreading of edge bits into odd positions;
- the register-by-register zero-read rules across the four combinations of secure attribute and security disable;
- the mirrored asleep bit.

// File: rtl/ibr_pkg.sv
package ibr_pkg;

   localparam logic [1:0] SZ_BYTE  = 2'd0;
   localparam logic [1:0] SZ_HALF  = 2'd1;
   localparam logic [1:0] SZ_WORD  = 2'd2;
   localparam logic [1:0] SZ_DWORD = 2'd3;

   localparam int unsigned OFF_WAKE   = 'h000;
   localparam int unsigned OFF_ID     = 'h008;
   localparam int unsigned OFF_ID_HI  = 'h00C;
   localparam int unsigned OFF_GROUP  = 'h080;
   localparam int unsigned OFF_EN_S   = 'h100;
   localparam int unsigned OFF_EN_C   = 'h180;
   localparam int unsigned OFF_PD_S   = 'h200;
   localparam int unsigned OFF_PD_C   = 'h280;
   localparam int unsigned OFF_AC_S   = 'h300;
   localparam int unsigned OFF_AC_C   = 'h380;
   localparam int unsigned OFF_PRIO   = 'h400;
   localparam int unsigned OFF_CFG0   = 'hC00;
   localparam int unsigned OFF_CFG1   = 'hC04;
   localparam int unsigned OFF_GMOD   = 'hD00;
   localparam int unsigned OFF_NSAC   = 'hE00;

   typedef enum logic [4:0] {
      SEL_NONE, SEL_WAKE, SEL_ID_LO, SEL_ID_HI, SEL_ID64, SEL_GROUP,
      SEL_EN_S, SEL_EN_C, SEL_PD_S, SEL_PD_C, SEL_AC_S, SEL_AC_C,
      SEL_PRIO, SEL_CFG0, SEL_CFG1, SEL_GMOD, SEL_NSAC
   } ibr_sel_e;

endpackage

// File: rtl/ibr_decode.sv
module ibr_decode
   import ibr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int N_IRQ  = 32,
   localparam int IDX_W = $clog2(N_IRQ)
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output ibr_sel_e          sel,
   output logic [IDX_W-1:0]  prio_base,
   output logic [3:0]        prio_lanes
);

   logic              in_prio;
   logic [ADDR_W-1:0] prio_off;

   assign in_prio  = (addr >= ADDR_W'(OFF_PRIO)) && (addr < ADDR_W'(OFF_PRIO + N_IRQ));
   assign prio_off = addr - ADDR_W'(OFF_PRIO);

   always_comb begin
      sel        = SEL_NONE;
      prio_base  = prio_off[IDX_W-1:0];
      prio_lanes = 4'b0000;
      unique case (size)
         SZ_BYTE: begin
            if (in_prio) begin
               sel        = SEL_PRIO;
               prio_lanes = 4'b0001;
            end
         end
         SZ_WORD: begin
            if (addr[1:0] == 2'b00) begin
               if (in_prio) begin
                  sel        = SEL_PRIO;
                  prio_lanes = 4'b1111;
               end else begin
                  case (addr)
                     ADDR_W'(OFF_WAKE):  sel = SEL_WAKE;
                     ADDR_W'(OFF_ID):    sel = SEL_ID_LO;
                     ADDR_W'(OFF_ID_HI): sel = SEL_ID_HI;
                     ADDR_W'(OFF_GROUP): sel = SEL_GROUP;
                     ADDR_W'(OFF_EN_S):  sel = SEL_EN_S;
                     ADDR_W'(OFF_EN_C):  sel = SEL_EN_C;
                     ADDR_W'(OFF_PD_S):  sel = SEL_PD_S;
                     ADDR_W'(OFF_PD_C):  sel = SEL_PD_C;
                     ADDR_W'(OFF_AC_S):  sel = SEL_AC_S;
                     ADDR_W'(OFF_AC_C):  sel = SEL_AC_C;
                     ADDR_W'(OFF_CFG0):  sel = SEL_CFG0;
                     ADDR_W'(OFF_CFG1):  sel = SEL_CFG1;
                     ADDR_W'(OFF_GMOD):  sel = SEL_GMOD;
                     ADDR_W'(OFF_NSAC):  sel = SEL_NSAC;
                     default:            sel = SEL_NONE;
                  endcase
               end
            end
         end
         SZ_DWORD: begin
            if (addr == ADDR_W'(OFF_ID)) sel = SEL_ID64;
         end
         default: sel = SEL_NONE;
      endcase
   end

endmodule

// File: rtl/ibr_bitmap.sv
module ibr_bitmap #(
   parameter int W = 32
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         set_en,
   input  logic         clr_en,
   input  logic [W-1:0] wval,
   input  logic [W-1:0] mask,
   output logic [W-1:0] q
);

   logic [W-1:0] hit;
   assign hit = wval & mask;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q <= '0;
      else if (set_en) q <= q | hit;
      else if (clr_en) q <= q & ~hit;
   end

endmodule

// File: rtl/ibr_prio_bank.sv
module ibr_prio_bank #(
   parameter int N_IRQ  = 32,
   parameter int PRIO_W = 8,
   localparam int IDX_W = $clog2(N_IRQ),
   localparam int LANES = 4
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic [IDX_W-1:0]        base,
   input  logic [LANES-1:0]        lanes,
   input  logic [LANES*PRIO_W-1:0] wdata,
   input  logic                    ns_view,
   input  logic [N_IRQ-1:0]        grp,
   output logic [LANES*PRIO_W-1:0] rdata
);

   logic [N_IRQ-1:0][PRIO_W-1:0] prio_all;

   for (genvar i = 0; i < N_IRQ; i++) begin : g_irq
      logic              hit;
      logic [PRIO_W-1:0] val;
      logic [PRIO_W-1:0] p_q;

      always_comb begin
         hit = 1'b0;
         val = '0;
         for (int k = 0; k < LANES; k++) begin
            if (lanes[k] && ((base + IDX_W'(k)) == IDX_W'(i))) begin
               hit = 1'b1;
               val = wdata[k*PRIO_W +: PRIO_W];
            end
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            p_q <= '0;
         end else if (wr && hit) begin
            if (!ns_view)    p_q <= val;
            else if (grp[i]) p_q <= {1'b1, val[PRIO_W-1:1]};
         end
      end

      assign prio_all[i] = p_q;
   end

   for (genvar k = 0; k < LANES; k++) begin : g_lane
      logic [IDX_W-1:0]  idx;
      logic [PRIO_W-1:0] p;
      assign idx = base + IDX_W'(k);
      assign p   = prio_all[idx];
      always_comb begin
         if (!ns_view)     rdata[k*PRIO_W +: PRIO_W] = p;
         else if (grp[idx]) rdata[k*PRIO_W +: PRIO_W] = {p[PRIO_W-2:0], 1'b0};
         else              rdata[k*PRIO_W +: PRIO_W] = '0;
      end
   end

endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
   import ibr_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter int          N_SGI    = 16,
   parameter int          N_IRQ    = 32,
   parameter int          PRIO_W   = 8,
   parameter logic [63:0] ID_VALUE = 64'h0000_0020_0A11_5E01,
   localparam int         IDX_W    = $clog2(N_IRQ),
   localparam int         N_PPI    = N_IRQ - N_SGI
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   input  logic [63:0]       wdata,
   input  logic              secure,
   input  logic              sec_dis,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [63:0]       rsp_rdata,
   output logic [N_IRQ-1:0]  en_map,
   output logic [N_IRQ-1:0]  pend_map,
   output logic [N_IRQ-1:0]  act_map,
   output logic [N_IRQ-1:0]  edge_map
);

   if (N_IRQ != 32) begin : g_chk_irq
      $error("irq_bank_regs: N_IRQ must equal the 32-bit register width");
   end
   if (N_SGI * 2 != N_IRQ) begin : g_chk_sgi
      $error("irq_bank_regs: N_SGI must be half of N_IRQ");
   end
   if (PRIO_W * 4 != 32) begin : g_chk_prio
      $error("irq_bank_regs: four priorities must fill one word");
   end
   if (ADDR_W < 12) begin : g_chk_addr
      $error("irq_bank_regs: ADDR_W too small for the register map");
   end

   ibr_sel_e         sel;
   logic [IDX_W-1:0] prio_base;
   logic [3:0]       prio_lanes;

   ibr_decode #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ)) u_dec (
      .addr(addr), .size(size), .sel(sel),
      .prio_base(prio_base), .prio_lanes(prio_lanes)
   );

   logic             wr;
   logic             restricted;
   logic             sec_only;
   logic [N_IRQ-1:0] mask;
   logic [N_IRQ-1:0] grp_q;
   logic [N_IRQ-1:0] gmod_q;
   logic [N_IRQ-1:0] nsac_q;
   logic [N_PPI-1:0] edge_hi_q;
   logic             sleep_q;

   assign wr         = req && we;
   assign restricted = !secure && !sec_dis;
   assign sec_only   = secure && !sec_dis;
   assign mask       = restricted ? grp_q : '1;

   // set/clear bitmaps: 0 enable, 1 pending, 2 active
   localparam int NB = 3;
   logic [NB-1:0]            set_en, clr_en;
   logic [NB-1:0][N_IRQ-1:0] bm_q;

   assign set_en = {wr && sel == SEL_AC_S, wr && sel == SEL_PD_S, wr && sel == SEL_EN_S};
   assign clr_en = {wr && sel == SEL_AC_C, wr && sel == SEL_PD_C, wr && sel == SEL_EN_C};

   for (genvar b = 0; b < NB; b++) begin : g_bm
      ibr_bitmap #(.W(N_IRQ)) u_bm (
         .clk(clk), .rst_n(rst_n), .set_en(set_en[b]), .clr_en(clr_en[b]),
         .wval(wdata[N_IRQ-1:0]), .mask(mask), .q(bm_q[b])
      );
   end

   assign en_map   = bm_q[0];
   assign pend_map = bm_q[1];
   assign act_map  = bm_q[2];
   assign edge_map = {edge_hi_q, {N_SGI{1'b0}}};

   logic [31:0] prio_rd;

   ibr_prio_bank #(.N_IRQ(N_IRQ), .PRIO_W(PRIO_W)) u_prio (
      .clk(clk), .rst_n(rst_n), .wr(wr && sel == SEL_PRIO),
      .base(prio_base), .lanes(prio_lanes), .wdata(wdata[31:0]),
      .ns_view(restricted), .grp(grp_q), .rdata(prio_rd)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         grp_q   <= '0;
         gmod_q  <= '0;
         nsac_q  <= '0;
         sleep_q <= 1'b0;
      end else if (wr) begin
         if (sel == SEL_GROUP && !restricted) grp_q  <= wdata[N_IRQ-1:0];
         if (sel == SEL_GMOD && sec_only)     gmod_q <= wdata[N_IRQ-1:0];
         if (sel == SEL_NSAC && sec_only)     nsac_q <= wdata[N_IRQ-1:0];
         if (sel == SEL_WAKE)                 sleep_q <= wdata[0];
      end
   end

   // edge bits of the upper half, odd positions of the second trigger word
   for (genvar k = 0; k < N_PPI; k++) begin : g_edge
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            edge_hi_q[k] <= 1'b0;
         else if (wr && sel == SEL_CFG1 && mask[N_SGI + k])
            edge_hi_q[k] <= wdata[2*k + 1];
      end
   end

   logic [N_IRQ-1:0] edge_vis;
   logic [N_SGI-1:0] cfg_half;
   logic [31:0]      cfg_rd;

   assign edge_vis = edge_map & mask;
   assign cfg_half = (sel == SEL_CFG1) ? edge_vis[N_IRQ-1:N_SGI] : edge_vis[N_SGI-1:0];

   for (genvar k = 0; k < N_SGI; k++) begin : g_spread
      assign cfg_rd[2*k]     = 1'b0;
      assign cfg_rd[2*k + 1] = cfg_half[k];
   end

   logic [63:0] rd_c;

   always_comb begin
      rd_c = '0;
      unique case (sel)
         SEL_WAKE:  rd_c[1:0] = {sleep_q, sleep_q};
         SEL_ID_LO: rd_c[31:0] = ID_VALUE[31:0];
         SEL_ID_HI: rd_c[31:0] = ID_VALUE[63:32];
         SEL_ID64:  rd_c = ID_VALUE;
         SEL_GROUP: rd_c[31:0] = restricted ? '0 : grp_q;
         SEL_EN_S, SEL_EN_C: rd_c[31:0] = bm_q[0] & mask;
         SEL_PD_S, SEL_PD_C: rd_c[31:0] = bm_q[1] & mask;
         SEL_AC_S, SEL_AC_C: rd_c[31:0] = bm_q[2] & mask;
         SEL_PRIO:  rd_c[31:0] = (size == SZ_BYTE) ? {24'b0, prio_rd[7:0]} : prio_rd;
         SEL_CFG0, SEL_CFG1: rd_c[31:0] = cfg_rd;
         SEL_GMOD:  rd_c[31:0] = sec_only ? gmod_q : '0;
         SEL_NSAC:  rd_c[31:0] = sec_only ? nsac_q : '0;
         default:   rd_c = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req;
         rsp_err   <= req && (sel == SEL_NONE);
         rsp_rdata <= (req && !we && sel != SEL_NONE) ? rd_c : '0;
      end
   end

endmodule

// File: rtl/ibr_chk.sv
module ibr_chk
   import ibr_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int N_IRQ  = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req,
   input logic              we,
   input logic [ADDR_W-1:0] addr,
   input logic [1:0]        size,
   input logic              secure,
   input logic              sec_dis,
   input logic              rsp_valid,
   input logic              rsp_err,
   input logic [63:0]       rsp_rdata,
   input logic [N_IRQ-1:0]  en_map,
   input logic [N_IRQ-1:0]  pend_map,
   input logic [N_IRQ-1:0]  act_map,
   input logic [N_IRQ-1:0]  edge_map,
   input logic [N_IRQ-1:0]  grp
);

   logic rwr;
   assign rwr = req && we && !secure && !sec_dis;

   // R2
   rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req |=> rsp_valid);

   // R2
   rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req |=> (!rsp_valid && !rsp_err));

   // R2
   misalign_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && size == SZ_WORD && addr[1:0] != 2'b00) |=> rsp_err);

   // R2
   err_zero_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));

   // R3
   ns_en_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rwr |=> (((en_map ^ $past(en_map)) & ~$past(grp)) == '0));

   // R3
   ns_pend_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rwr |=> (((pend_map ^ $past(pend_map)) & ~$past(grp)) == '0));

   // R3
   ns_act_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rwr |=> (((act_map ^ $past(act_map)) & ~$past(grp)) == '0));

   // R3
   ns_edge_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rwr |=> (((edge_map ^ $past(edge_map)) & ~$past(grp)) == '0));

   // R4
   en_clr_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && size == SZ_WORD && addr == ADDR_W'(OFF_EN_C))
         |=> ((en_map & ~$past(en_map)) == '0));

   // R9
   cfg0_wi_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (req && we && size == SZ_WORD && addr == ADDR_W'(OFF_CFG0)) |=> $stable(edge_map));

endmodule

bind irq_bank_regs ibr_chk #(.ADDR_W(ADDR_W), .N_IRQ(N_IRQ)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
   .secure(secure), .sec_dis(sec_dis), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
   .rsp_rdata(rsp_rdata), .en_map(en_map), .pend_map(pend_map), .act_map(act_map),
   .edge_map(edge_map), .grp(grp_q)
);

// File: tb/sim_irq_bank_regs.sv
`timescale 1ns/1ps
module sim_irq_bank_regs;

   localparam logic [63:0] IDV = 64'h0000_0020_0A11_5E01;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req = 1'b0, we = 1'b0, secure = 1'b0, sec_dis = 1'b0;
   logic [15:0] addr = '0;
   logic [1:0]  size = '0;
   logic [63:0] wdata = '0;
   logic        rsp_valid, rsp_err;
   logic [63:0] rsp_rdata;
   logic [31:0] en_map, pend_map, act_map, edge_map;

   always #4 clk = ~clk;

   irq_bank_regs u0 (
      .clk(clk), .rst_n(rst_n), .req(req), .we(we), .addr(addr), .size(size),
      .wdata(wdata), .secure(secure), .sec_dis(sec_dis), .rsp_valid(rsp_valid),
      .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .en_map(en_map), .pend_map(pend_map),
      .act_map(act_map), .edge_map(edge_map)
   );

   typedef struct packed {
      logic        w;
      logic        s;
      logic        d;
      logic [1:0]  z;
      logic [15:0] a;
      logic [63:0] wd;
      logic [63:0] ex;
      logic        er;
      logic [3:0]  rq;
   } vec_t;

   localparam int NV = 58;
   // s=1,d=0 secure; s=0,d=0 restricted; z: 0 byte, 1 half, 2 word, 3 dword
   localparam vec_t TBL [NV] = '{
      '{1,1,0,2,16'h080,64'h0000FF00,64'h0,0,5},   // R5
      '{0,1,0,2,16'h080,64'h0,64'h0000FF00,0,5},
      '{0,0,0,2,16'h080,64'h0,64'h0,0,5},
      '{1,0,0,2,16'h080,64'hFFFFFFFF,64'h0,0,5},
      '{0,1,0,2,16'h080,64'h0,64'h0000FF00,0,5},
      '{1,0,0,2,16'h100,64'hFFFFFFFF,64'h0,0,3},   // R3
      '{0,1,0,2,16'h180,64'h0,64'h0000FF00,0,4},   // R4
      '{1,1,0,2,16'h100,64'h3,64'h0,0,4},
      '{0,0,0,2,16'h100,64'h0,64'h0000FF00,0,3},
      '{1,0,0,2,16'h180,64'hFFFFFFFF,64'h0,0,3},
      '{0,1,0,2,16'h100,64'h0,64'h3,0,4},
      '{1,0,1,2,16'h200,64'hF0000000,64'h0,0,3},
      '{0,0,1,2,16'h280,64'h0,64'hF0000000,0,3},
      '{0,0,0,2,16'h200,64'h0,64'h0,0,3},
      '{1,1,0,2,16'h300,64'h00010100,64'h0,0,4},
      '{0,0,0,2,16'h380,64'h0,64'h00000100,0,3},
      '{1,0,0,0,16'h408,64'h40,64'h0,0,7},         // R7
      '{0,1,0,0,16'h408,64'h0,64'hA0,0,7},
      '{0,0,0,0,16'h408,64'h0,64'h40,0,6},         // R6
      '{1,0,0,0,16'h400,64'h55,64'h0,0,7},
      '{0,1,0,0,16'h400,64'h0,64'h0,0,7},
      '{1,1,0,2,16'h404,64'h44332211,64'h0,0,8},   // R8
      '{0,1,0,0,16'h406,64'h0,64'h33,0,8},
      '{1,0,0,2,16'h408,64'h10203040,64'h0,0,7},
      '{0,1,0,2,16'h408,64'h0,64'h889098A0,0,8},
      '{0,0,0,2,16'h408,64'h0,64'h10203040,0,6},
      '{0,0,0,2,16'h404,64'h0,64'h0,0,6},
      '{1,1,0,2,16'hC04,64'hAAAAAAAA,64'h0,0,9},   // R9
      '{0,0,0,2,16'hC04,64'h0,64'h0,0,9},
      '{1,1,0,2,16'h080,64'h00FF0000,64'h0,0,5},
      '{1,0,0,2,16'hC04,64'h0,64'h0,0,9},
      '{0,1,0,2,16'hC04,64'h0,64'hAAAA0000,0,9},
      '{1,1,0,2,16'hC00,64'hFFFFFFFF,64'h0,0,9},
      '{0,1,0,2,16'hC00,64'h0,64'h0,0,9},
      '{1,1,0,2,16'hD00,64'h1234,64'h0,0,10},      // R10
      '{0,1,0,2,16'hD00,64'h0,64'h1234,0,10},
      '{0,0,0,2,16'hD00,64'h0,64'h0,0,10},
      '{0,1,1,2,16'hD00,64'h0,64'h0,0,10},
      '{1,0,0,2,16'hD00,64'hFFFF,64'h0,0,10},
      '{0,1,0,2,16'hD00,64'h0,64'h1234,0,10},
      '{1,1,0,2,16'hE00,64'hC,64'h0,0,10},
      '{0,1,0,2,16'hE00,64'h0,64'hC,0,10},
      '{0,1,1,2,16'hE00,64'h0,64'h0,0,10},
      '{1,1,0,2,16'h000,64'h1,64'h0,0,11},         // R11
      '{0,1,0,2,16'h000,64'h0,64'h3,0,11},
      '{1,1,0,2,16'h000,64'h2,64'h0,0,11},
      '{0,1,0,2,16'h000,64'h0,64'h0,0,11},
      '{0,1,0,2,16'h008,64'h0,{32'h0,IDV[31:0]},0,12},  // R12
      '{0,1,0,2,16'h00C,64'h0,{32'h0,IDV[63:32]},0,12},
      '{1,1,0,3,16'h008,64'hFFFFFFFF,64'h0,0,12},
      '{0,1,0,3,16'h008,64'h0,IDV,0,12},
      '{0,1,0,1,16'h080,64'h0,64'h0,1,2},          // R2
      '{0,1,0,2,16'h500,64'h0,64'h0,1,2},
      '{0,1,0,0,16'h080,64'h0,64'h0,1,2},
      '{1,1,0,2,16'h402,64'h5,64'h0,1,2},
      '{0,1,0,3,16'h100,64'h0,64'h0,1,2},
      '{1,1,0,0,16'h408,64'h77,64'h0,0,8},
      '{0,1,0,2,16'h408,64'h0,64'h88909877,0,8}
   };

   int  n_run = 0;
   int  n_fail = 0;
   bit  done = 1'b0;

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_run++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic access(input vec_t v);
      @(negedge clk);
      req = 1'b1; we = v.w; secure = v.s; sec_dis = v.d; size = v.z;
      addr = v.a; wdata = v.wd;
      @(negedge clk);
      req = 1'b0; we = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 maps", {en_map | pend_map, act_map | edge_map}, 64'h0);
      check("R1 rsp", {63'h0, rsp_valid | rsp_err}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);
      access('{0,1,0,0,16'h41F,64'h0,64'h0,0,1});
      check("R1 prio31", rsp_rdata, 64'h0);

      for (int i = 0; i < NV; i++) begin
         access(TBL[i]);
         check($sformatf("R%0d row%0d valid", TBL[i].rq, i), {63'h0, rsp_valid}, 64'h1);
         check($sformatf("R%0d row%0d err", TBL[i].rq, i), {63'h0, rsp_err}, {63'h0, TBL[i].er});
         check($sformatf("R%0d row%0d data", TBL[i].rq, i), rsp_rdata, TBL[i].ex);
      end

      // R3 R4 R9 bitmaps at the ports
      check("R4 en_map", {32'h0, en_map}, 64'h00000003);
      check("R3 pend_map", {32'h0, pend_map}, 64'hF0000000);
      check("R4 act_map", {32'h0, act_map}, 64'h00010100);
      check("R9 edge_map", {32'h0, edge_map}, 64'hFF000000);

      // R2 no response without a request
      @(negedge clk);
      check("R2 idle", {62'h0, rsp_valid, rsp_err}, 64'h0);

      // R3 restricted clear of pending hits only group-1 bits (group now 00FF0000)
      access('{1,1,0,2,16'h200,64'h00F00000,64'h0,0,3});
      access('{1,0,0,2,16'h280,64'hFFFFFFFF,64'h0,0,3});
      check("R3 ns clear pend", {32'h0, pend_map}, 64'hF0000000);

      // R1 reset mid-run clears state
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rereset maps", {en_map | pend_map, act_map | edge_map}, 64'h0);
      rst_n = 1'b1;
      access('{0,1,0,2,16'h408,64'h0,64'h0,0,1});
      check("R1 rereset prio", rsp_rdata, 64'h0);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule